// File: doc/BRIEF.md
# Board Interrupt Level Aggregator

This block gathers thirteen level-sensitive interrupt lines from board peripherals and presents a processor with a single 4-bit encoded interrupt level. Each source owns a fixed priority level (0 is the most urgent, 12 the least) and a fixed bit in a 16-bit pending word. A software-written 16-bit enable word selects which sources take part. The most urgent enabled and pending source wins, and its level is driven out inverted, so an idle output reads 0.

A 16-bit register port with a 64-byte window gives access to the enable word, a general-purpose output latch that drives a pin bus, a fixed version code, and a power-off control. Writing bit 0 of the power-off control raises a one-cycle shutdown request. The encoded level and the shutdown request both leave the block from flops.

Top module: `irq_level_aggr`

## Requirements
- R1: The pending word follows the source inputs whatever the enable word holds. Source level L occupies a fixed bit: L0→11, L1→9, L2→8, L3→12, L4→10, L5→6, L6→5, L7→4, L8→7, L9→14, L10→13, L11→0, L12→15. Bits 1, 2 and 3 are always 0. A source that was raised while disabled is reported as soon as it is enabled, without being toggled again.
- R2: A source takes part only when its pending bit and its enable bit are both 1.
- R3: Among the sources that take part, the smallest level wins. When none takes part, the selected level is 15.
- R4: irl_o equals the selected level XOR 15. It is 0 when nothing is pending and 15 when the level-0 source wins.
- R5: A change on src_i is captured at one rising edge and shows on irl_o after the next edge. An enable-word write that is captured at one edge shows on irl_o after the next edge.
- R6: Byte offset 0x00 holds the enable word, which reads back all 16 bits as they were written.
- R7: Byte offset 0x36 holds the output latch. It reads back as written and drives port_o.
- R8: Byte offset 0x32 always reads 0x0010, and writes to it change nothing.
- R9: Byte offset 0x30 reads 0. A write there with wdata_i bit 0 set raises shutdown_o for exactly the one cycle after the edge that captures the write. A write with bit 0 clear raises nothing.
- R10: Any other offset, odd offsets included, reads 0, and writes to it change neither the enable word nor the output latch. rdata_o is 0 while rd_en_i is low.
- R11: After reset the enable word, the pending word and the output latch are 0, irl_o is 0 and shutdown_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 13 | Interrupt sources, indexed by priority level |
| addr_i | input | 6 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| port_o | output | 16 | General-purpose output latch |
| irl_o | output | 4 | Inverted encoded interrupt level |
| shutdown_o | output | 1 | One-cycle shutdown request |

## Verification
The bench raises every pair of sources with all sources enabled. A design that ordered by bit position rather than by level would pick the wrong winner in pairs such as levels 3 and 4, whose bits are 12 and 10. It sweeps single enable bits with every source pending, including the unused bits 1 to 3, and runs pseudo-random source and enable patterns to catch encoders that ignore the enable word or skip the XOR. It checks the exact two-edge latency, a source that is enabled after it was raised, a version write that must not stick, writes to unmapped and odd offsets that must not alias onto real registers, and a shutdown request that must be a single pulse gated by bit 0 alone.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int NUM_SRC = 13;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int LVL_W   = 4;
  localparam logic [LVL_W-1:0] LVL_NONE = '1;

  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_VER  = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_PORT = 6'h36;

  // status-word bit owned by each priority level
  function automatic int unsigned lvl_bit(input int unsigned lvl);
    case (lvl)
      0: return 11;  1: return 9;   2: return 8;   3: return 12;
      4: return 10;  5: return 6;   6: return 5;   7: return 4;
      8: return 7;   9: return 14;  10: return 13; 11: return 0;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_status.sv
module irq_src_status
  import irq_aggr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] status_d;

  always_comb begin
    status_d = '0;
    for (int l = 0; l < NUM_SRC; l++) status_d[lvl_bit(l)] = src_i[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_o <= '0;
    else         status_o <= status_d;
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import irq_aggr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [LVL_W-1:0]  irl_o
);
  logic [DATA_W-1:0] qual;
  logic [LVL_W-1:0]  sel;

  assign qual = status_i & mask_i;

  // walk from least to most urgent so the smallest level is left standing
  always_comb begin
    sel = LVL_NONE;
    for (int l = NUM_SRC - 1; l >= 0; l--)
      if (qual[lvl_bit(l)]) sel = LVL_W'(l);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irl_o <= '0;
    else         irl_o <= sel ^ LVL_NONE;
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_aggr_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] port_o,
  output logic              shutdown_o
);
  logic hit_mask, hit_port, hit_pwr, hit_ver;

  assign hit_mask = (addr_i == OFS_MASK);
  assign hit_port = (addr_i == OFS_PORT);
  assign hit_pwr  = (addr_i == OFS_PWR);
  assign hit_ver  = (addr_i == OFS_VER);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mask_o     <= '0;
      port_o     <= '0;
      shutdown_o <= 1'b0;
    end else begin
      if (wr_en_i && hit_mask) mask_o <= wdata_i;
      if (wr_en_i && hit_port) port_o <= wdata_i;
      shutdown_o <= wr_en_i && hit_pwr && wdata_i[0];
    end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (hit_mask)     rdata_o = mask_o;
      else if (hit_port) rdata_o = port_o;
      else if (hit_ver)  rdata_o = VERSION;
    end
  end
endmodule

// File: rtl/irq_level_aggr.sv
module irq_level_aggr
  import irq_aggr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [DATA_W-1:0]  port_o,
  output logic [LVL_W-1:0]   irl_o,
  output logic               shutdown_o
);
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] mask_w;

  irq_src_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .status_o (status_w)
  );

  irq_reg_bank u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .mask_o     (mask_w),
    .port_o     (port_o),
    .shutdown_o (shutdown_o)
  );

  irq_prio_encoder u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_w),
    .mask_i   (mask_w),
    .irl_o    (irl_o)
  );
endmodule

// File: rtl/irq_level_aggr_chk.sv
module irq_level_aggr_chk
  import irq_aggr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [DATA_W-1:0]  port_o,
  input logic [LVL_W-1:0]   irl_o,
  input logic               shutdown_o,
  input logic [DATA_W-1:0]  status_w,
  input logic [DATA_W-1:0]  mask_w
);
  a_r9_shutdown_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> $past(wr_en_i && addr_i == OFS_PWR && wdata_i[0]));

  a_r9_pwr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_PWR) |-> rdata_o == '0);

  a_r8_version_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_VER) |-> rdata_o == 16'h0010);

  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_w & mask_w) == '0) |-> irl_o == '0);

  a_r3_level0_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_w[11] & mask_w[11]) |-> irl_o == 4'hF);

  a_r1_unused_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[3:1] == 3'b000);

  a_r7_port_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && addr_i == OFS_PORT) |-> $stable(port_o));

  a_r10_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
endmodule

bind irq_level_aggr irq_level_aggr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .port_o     (port_o),
  .irl_o      (irl_o),
  .shutdown_o (shutdown_o),
  .status_w   (status_w),
  .mask_w     (mask_w)
);

// File: tb/test_irq_level_aggr.sv
`timescale 1ns/1ps
module test_irq_level_aggr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] src_i = '0;
  logic [5:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [15:0] port_o;
  logic [3:0]  irl_o;
  logic        shutdown_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_level_aggr i_irq_level_aggr (.*);

  int bit_of [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  function automatic logic [3:0] model(input logic [12:0] s, input logic [15:0] m);
    for (int l = 0; l < 13; l++)
      if (s[l] && m[bit_of[l]]) return 4'(l) ^ 4'hF;
    return 4'h0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check("R11 irl", {12'h0, irl_o}, 16'h0);
    check("R11 shutdown", {15'h0, shutdown_o}, 16'h0);
    check("R11 port", port_o, 16'h0);
    rd(6'h00, d); check("R11 mask", d, 16'h0);
    rd(6'h36, d); check("R11 port read", d, 16'h0);

    // R1 source pending while disabled, then enabled
    @(negedge clk_i); src_i = 13'h1 << 4;
    settle(); check("R1 disabled src", {12'h0, irl_o}, 16'h0);
    wr(6'h00, 16'h1 << 10);
    // R5 mask write captured at the last edge; one edge later the output moves
    check("R5 before", {12'h0, irl_o}, 16'h0);
    @(negedge clk_i); check("R1 R5 enabled late", {12'h0, irl_o}, 16'd4 ^ 16'hF);

    // R6 mask readback
    wr(6'h00, 16'hFFFF); rd(6'h00, d); check("R6 mask rb", d, 16'hFFFF);

    // R5 source latency
    @(negedge clk_i); src_i = 13'h1;
    @(negedge clk_i); check("R5 one edge", {12'h0, irl_o}, 16'd4 ^ 16'hF);
    @(negedge clk_i); check("R5 two edges", {12'h0, irl_o}, 16'hF);

    // R3 R4 all pairs with full enable
    for (int a = 0; a < 13; a++)
      for (int b = 0; b < 13; b++) begin
        @(negedge clk_i); src_i = (13'h1 << a) | (13'h1 << b);
        settle();
        check("R3 R4 pair", {12'h0, irl_o}, {12'h0, 4'((a < b) ? a : b) ^ 4'hF});
      end
    @(negedge clk_i); src_i = '0; settle();
    check("R4 none", {12'h0, irl_o}, 16'h0);

    // R2 single enable bit with all sources pending
    @(negedge clk_i); src_i = '1;
    for (int m = 0; m < 16; m++) begin
      wr(6'h00, 16'h1 << m); settle();
      check("R2 single mask", {12'h0, irl_o}, {12'h0, model('1, 16'h1 << m)});
    end

    // R2 R3 pseudo-random patterns
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr(6'h00, lfsr[31:16] & lfsr[15:0] | lfsr[23:8]);
      @(negedge clk_i); src_i = lfsr[12:0] & lfsr[28:16];
      settle();
      check("R2 R3 random", {12'h0, irl_o},
            {12'h0, model(lfsr[12:0] & lfsr[28:16], lfsr[31:16] & lfsr[15:0] | lfsr[23:8])});
    end

    // R7 output port
    wr(6'h36, 16'hA55A);
    check("R7 port pins", port_o, 16'hA55A);
    rd(6'h36, d); check("R7 port rb", d, 16'hA55A);

    // R8 version
    rd(6'h32, d); check("R8 version", d, 16'h0010);
    wr(6'h32, 16'h1234); rd(6'h32, d); check("R8 write ignored", d, 16'h0010);

    // R10 unmapped / odd offsets
    wr(6'h00, 16'h0F0F);
    wr(6'h02, 16'hFFFF); wr(6'h37, 16'h0000); wr(6'h01, 16'hFFFF); wr(6'h3E, 16'h1111);
    rd(6'h00, d); check("R10 mask untouched", d, 16'h0F0F);
    rd(6'h36, d); check("R10 port untouched", d, 16'hA55A);
    rd(6'h02, d); check("R10 unmapped read", d, 16'h0);
    rd(6'h37, d); check("R10 odd read", d, 16'h0);
    @(negedge clk_i); addr_i = 6'h36; #1 check("R10 no rd_en", rdata_o, 16'h0);

    // R9 power-off
    rd(6'h30, d); check("R9 pwr read", d, 16'h0);
    check("R9 idle", {15'h0, shutdown_o}, 16'h0);
    wr(6'h30, 16'h0002);
    check("R9 bit0 clear", {15'h0, shutdown_o}, 16'h0);
    wr(6'h30, 16'h0001);
    check("R9 pulse high", {15'h0, shutdown_o}, 16'h1);
    @(negedge clk_i); check("R9 pulse low", {15'h0, shutdown_o}, 16'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule